// File: doc/BRIEF.md
# Pointer-Indexed Dual-Channel Register Port

This block is the host-side register port of a two-channel serial controller. A host reaches the registers of both channels over one 8-bit bus. It uses a chip enable, separate read and write strobes, a channel select pin and a mode pin that selects data or control. Each channel has sixteen write registers, which the block stores and presents as a flat output vector. Each channel also has sixteen read registers, which are supplied from outside on a flat input vector.

Control-mode access is indirect. A control write to register 0 loads one shared index. The index is four bits wide: three bits come straight from the written byte, and the upper bit is set only by a "point high" command carried in the same byte. The next control-mode read or write goes to the indexed register of the channel that the channel pin selects during that access. When that access ends, the index returns to zero. The host can therefore always reach register 0 in a single cycle. A control read is also the way to recover the index when its state is unknown. Data-mode accesses go straight to register 8, which is the receive buffer on reads and the transmit buffer on writes. A data-mode access ignores the index and leaves it unchanged.

Bus accesses are sampled on the system clock by a three-state machine. ST_IDLE moves to ST_READ when chip enable and read are high without write. ST_IDLE moves to ST_WRITE when chip enable and write are high without read. If both strobes are high, ST_IDLE stays in ST_IDLE. ST_READ returns to ST_IDLE, producing a read-done pulse, on the first cycle the read access is gone. ST_WRITE returns to ST_IDLE, producing a write-done pulse, on the first cycle the write access is gone. Every effect of an access (register update, index load or clear, command strobe) happens at the clock edge that ends it.

Top module: `regport_top`

## Requirements
- R1: After reset the index is 0, all write registers read 0, `cmd_stb` is 0 and `bus_rdata_oe` is 0.
- R2: A control write while the index is 0 stores the whole byte in write register 0 of the selected channel and loads index bits 2..0 from data bits 2..0. The following control access then targets that register.
- R3: The index returns to 0 when any control-mode read or write ends. This includes a control read used only to clear the index.
- R4: There is one index for both channels. The channel is the value of `bus_ch` (0 = channel A, 1 = channel B) during the register access itself, not during the index write.
- R5: When data bits 5..3 equal 3'b001 (point high) in a control write to register 0, index bit 3 is set, reaching registers 8..15. Any other value clears bit 3.
- R6: A data-mode read (`bus_dc`=1) returns read register 8 of the selected channel. A data-mode write stores the byte in write register 8 of that channel. Neither changes the index.
- R7: Reaching register 8 through the index gives the same result as a data-mode access.
- R8: A control write to register 0 with data bits 5..3 neither 3'b000 nor 3'b001 raises `cmd_stb` for exactly one cycle after the access ends, with that value on `cmd_code`. Values 3'b000 and 3'b001 give no strobe.
- R9: `bus_rdata_oe` is high exactly while `bus_ce` and `bus_rd` are both high. While it is high, `bus_rdata` shows the read register chosen by the current mode, index and channel. Otherwise `bus_rdata` is 0.
- R10: A write register changes only at the clock edge after the write strobe drops, and it takes the bus value of the last strobe cycle. A cycle with read and write both high is not an access and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_ce | input | 1 | Chip enable, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_dc | input | 1 | 1 = data mode (buffer), 0 = control mode (indexed) |
| bus_ch | input | 1 | Channel select, 0 = A, 1 = B |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_rdata_oe | output | 1 | Read data drive enable |
| rreg_in | input | 256 | Read registers, byte (ch*16+reg) |
| wreg_out | output | 256 | Write registers, byte (ch*16+reg) |
| cmd_stb | output | 1 | One-cycle strobe for a non-pointer command |
| cmd_code | output | 3 | Command value reported with `cmd_stb` |

## Verification
A wrong index is visible on the next control access. If the index is stale or not cleared, a control read returns the wrong read register as soon as the strobe is high, or a control write lands in the wrong byte of `wreg_out` one edge after the strobe drops. A lost point-high bit or a wrong channel shows up the same way, as data in the wrong register or the wrong channel. A state machine that commits too early or twice shows as a write register that changes while the strobe is still high, or as a `cmd_stb` that lasts more than one cycle.

// File: rtl/regport_pkg.sv
package regport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_state_e;

    localparam int CMD_W          = 3;
    localparam logic [CMD_W-1:0] CMD_NULL       = 3'b000;
    localparam logic [CMD_W-1:0] CMD_POINT_HIGH = 3'b001;

endpackage

// File: rtl/regport_fsm.sv
module regport_fsm
    import regport_pkg::*;
#(
    parameter int DW      = 8,
    parameter int AW      = 4,
    parameter int CHW     = 1,
    parameter int BUF_IDX = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce,
    input  logic           rd,
    input  logic           wr,
    input  logic           dc,
    input  logic [CHW-1:0] ch,
    input  logic [DW-1:0]  wdata,
    input  logic [AW-1:0]  ptr,
    output logic           wr_done,
    output logic           rd_done,
    output logic           done_dc,
    output logic [CHW-1:0] done_ch,
    output logic [AW-1:0]  done_addr,
    output logic [DW-1:0]  done_data
);

    acc_state_e state, state_nx;
    logic acc_rd, acc_wr;

    always_comb begin
        acc_rd = ce && rd && !wr;
        acc_wr = ce && wr && !rd;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (acc_wr)      state_nx = ST_WRITE;
                else if (acc_rd) state_nx = ST_READ;
            end
            ST_READ:  if (!acc_rd) state_nx = ST_IDLE;
            ST_WRITE: if (!acc_wr) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        wr_done = 1'b0;
        rd_done = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_READ:  rd_done = !acc_rd;
            ST_WRITE: wr_done = !acc_wr;
            default:  ;
        endcase
    end

    // Access attributes captured every active cycle; the last cycle wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_dc   <= 1'b0;
            done_ch   <= '0;
            done_addr <= '0;
            done_data <= '0;
        end else if (acc_rd || acc_wr) begin
            done_dc   <= dc;
            done_ch   <= ch;
            done_addr <= dc ? AW'(BUF_IDX) : ptr;
            done_data <= wdata;
        end
    end

    a_r10_one_done: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_done, rd_done}));

    a_r10_dual_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ce && rd && wr) |=> (state == ST_IDLE));

endmodule

// File: rtl/regport_ptr.sv
module regport_ptr
    import regport_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_done,
    input  logic             rd_done,
    input  logic             done_dc,
    input  logic [AW-1:0]    done_addr,
    input  logic [DW-1:0]    done_data,
    output logic [AW-1:0]    ptr,
    output logic             cmd_stb,
    output logic [CMD_W-1:0] cmd_code
);

    localparam int LOW_W = AW - 1;

    logic             ctrl_end;
    logic             load;
    logic [CMD_W-1:0] cmd;

    always_comb begin
        ctrl_end = (wr_done || rd_done) && !done_dc;
        load     = wr_done && !done_dc && (done_addr == '0);
        cmd      = done_data[LOW_W +: CMD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr      <= '0;
            cmd_stb  <= 1'b0;
            cmd_code <= '0;
        end else begin
            cmd_stb <= 1'b0;
            if (load) begin
                ptr <= {cmd == CMD_POINT_HIGH, done_data[LOW_W-1:0]};
                if (cmd != CMD_NULL && cmd != CMD_POINT_HIGH) begin
                    cmd_stb  <= 1'b1;
                    cmd_code <= cmd;
                end
            end else if (ctrl_end) begin
                ptr <= '0;
            end
        end
    end

    a_r3_clear_after_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_end && !load) |=> (ptr == '0));

    a_r6_data_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_done || rd_done) && done_dc) |=> $stable(ptr));

    a_r5_point_high: assert property (@(posedge clk) disable iff (!rst_n)
        (load && cmd == CMD_POINT_HIGH) |=> ptr[AW-1]);

    a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

endmodule

// File: rtl/regport_wbank.sv
module regport_wbank #(
    parameter int DW   = 8,
    parameter int AW   = 4,
    parameter int NCH  = 2,
    parameter int CHW  = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_done,
    input  logic [CHW-1:0]             done_ch,
    input  logic [AW-1:0]              done_addr,
    input  logic [DW-1:0]              done_data,
    output logic [NCH*(1<<AW)*DW-1:0]  wreg_flat
);

    localparam int NREG = 1 << AW;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_done && done_ch == CHW'(c) && done_addr == AW'(r))
                    q <= done_data;
            end
            assign wreg_flat[(c*NREG + r)*DW +: DW] = q;
        end
    end

    a_r10_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_done |=> $stable(wreg_flat));

endmodule

// File: rtl/regport_top.sv
module regport_top
    import regport_pkg::*;
#(
    parameter int DW      = 8,
    parameter int AW      = 4,
    parameter int NCH     = 2,
    parameter int BUF_IDX = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_ce,
    input  logic                          bus_rd,
    input  logic                          bus_wr,
    input  logic                          bus_dc,
    input  logic                          bus_ch,
    input  logic [DW-1:0]                 bus_wdata,
    output logic [DW-1:0]                 bus_rdata,
    output logic                          bus_rdata_oe,
    input  logic [NCH*(1<<AW)*DW-1:0]     rreg_in,
    output logic [NCH*(1<<AW)*DW-1:0]     wreg_out,
    output logic                          cmd_stb,
    output logic [CMD_W-1:0]              cmd_code
);

    localparam int NREG = 1 << AW;
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;

    logic [AW-1:0]  ptr;
    logic           wr_done, rd_done, done_dc;
    logic [CHW-1:0] done_ch;
    logic [AW-1:0]  done_addr;
    logic [DW-1:0]  done_data;
    logic [CHW-1:0] ch_sel;
    logic [AW-1:0]  raddr;
    logic [DW-1:0]  rsel;

    assign ch_sel = CHW'(bus_ch);

    regport_fsm #(.DW(DW), .AW(AW), .CHW(CHW), .BUF_IDX(BUF_IDX)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ce(bus_ce), .rd(bus_rd), .wr(bus_wr), .dc(bus_dc), .ch(ch_sel),
        .wdata(bus_wdata), .ptr(ptr),
        .wr_done(wr_done), .rd_done(rd_done), .done_dc(done_dc),
        .done_ch(done_ch), .done_addr(done_addr), .done_data(done_data)
    );

    regport_ptr #(.DW(DW), .AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .wr_done(wr_done), .rd_done(rd_done), .done_dc(done_dc),
        .done_addr(done_addr), .done_data(done_data),
        .ptr(ptr), .cmd_stb(cmd_stb), .cmd_code(cmd_code)
    );

    regport_wbank #(.DW(DW), .AW(AW), .NCH(NCH), .CHW(CHW)) u_wbank (
        .clk(clk), .rst_n(rst_n),
        .wr_done(wr_done), .done_ch(done_ch), .done_addr(done_addr),
        .done_data(done_data), .wreg_flat(wreg_out)
    );

    // Read path: the index only moves at the end of an access, so the live
    // value is the one present at the start of the current cycle.
    always_comb begin
        raddr        = bus_dc ? AW'(BUF_IDX) : ptr;
        rsel         = rreg_in[(int'(ch_sel)*NREG + int'(raddr))*DW +: DW];
        bus_rdata_oe = bus_ce && bus_rd;
        bus_rdata    = bus_rdata_oe ? rsel : '0;
    end

    a_r9_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd) |-> (!bus_rdata_oe && bus_rdata == '0));

endmodule

// File: tb/regport_top_test.sv
module regport_top_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_ce = 0, bus_rd = 0, bus_wr = 0, bus_dc = 0, bus_ch = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic bus_rdata_oe;
    logic [255:0] rreg_in;
    logic [255:0] wreg_out;
    logic cmd_stb;
    logic [2:0] cmd_code;

    int n_tests = 0;
    int n_fail = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       mon_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regport_top uut (
        .clk(clk), .rst_n(rst_n),
        .bus_ce(bus_ce), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dc(bus_dc),
        .bus_ch(bus_ch), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
        .rreg_in(rreg_in), .wreg_out(wreg_out),
        .cmd_stb(cmd_stb), .cmd_code(cmd_code)
    );

    function automatic logic [7:0] rr_val(int c, int r);
        return 8'(c*128 + r*7 + 3);
    endfunction

    function automatic logic [7:0] wr_of(int c, int r);
        return wreg_out[(c*16 + r)*8 +: 8];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected item per sampled read strobe.
    always begin
        @(negedge clk);
        #1;
        if (mon_req) begin
            string t;
            logic [7:0] e;
            mon_req = 1'b0;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " oe"}, 32'(bus_rdata_oe), 32'd1);
            check(t, 32'(bus_rdata), 32'(e));
        end
    end

    task automatic bus_read(logic ch, logic dc, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_ce = 1; bus_rd = 1; bus_wr = 0; bus_dc = dc; bus_ch = ch;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        mon_req = 1'b1;
        @(negedge clk);
        bus_ce = 0; bus_rd = 0;
        @(negedge clk);
    endtask

    task automatic bus_write(logic ch, logic dc, logic [7:0] d);
        @(negedge clk);
        bus_ce = 1; bus_wr = 1; bus_rd = 0; bus_dc = dc; bus_ch = ch; bus_wdata = d;
        @(negedge clk);
        bus_ce = 0; bus_wr = 0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 16; r++)
                rreg_in[(c*16 + r)*8 +: 8] = rr_val(c, r);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 wregs", 32'(wreg_out == '0), 32'd1);
        check("R1 cmd_stb", 32'(cmd_stb), 32'd0);
        check("R1 oe", 32'(bus_rdata_oe), 32'd0);
        // R1 index is 0: control read hits register 0
        bus_read(1'b0, 1'b0, rr_val(0, 0), "R1 ptr zero");

        // R2 load index 5 through channel A, no command
        bus_write(1'b0, 1'b0, 8'h05);
        check("R2 wr0 byte", 32'(wr_of(0, 0)), 32'h05);
        check("R8 null cmd no stb", 32'(cmd_stb), 32'd0);
        // R4 register access through channel B
        bus_write(1'b1, 1'b0, 8'h5A);
        check("R4 B reg5", 32'(wr_of(1, 5)), 32'h5A);
        check("R4 A reg5 untouched", 32'(wr_of(0, 5)), 32'h00);

        // R3 index cleared: this write lands in reg 0, command 110, index 3
        bus_write(1'b0, 1'b0, 8'h33);
        check("R3 write to reg0 after clear", 32'(wr_of(0, 0)), 32'h33);
        check("R8 stb", 32'(cmd_stb), 32'd1);
        check("R8 code", 32'(cmd_code), 32'd6);
        @(negedge clk);
        check("R8 stb one cycle", 32'(cmd_stb), 32'd0);
        bus_read(1'b1, 1'b0, rr_val(1, 3), "R2 R4 read B reg3");
        bus_read(1'b0, 1'b0, rr_val(0, 0), "R3 read clears index");

        // R5 point high, index 14
        bus_write(1'b0, 1'b0, 8'h0E);
        check("R5 no stb for point high", 32'(cmd_stb), 32'd0);
        bus_read(1'b1, 1'b0, rr_val(1, 14), "R5 read B reg14");
        // R5 index 6 with command 000 keeps bit 3 clear
        bus_write(1'b0, 1'b0, 8'h06);
        bus_read(1'b0, 1'b0, rr_val(0, 6), "R5 low half");

        // R6 data-mode access with index 2 pending
        bus_write(1'b0, 1'b0, 8'h02);
        bus_read(1'b0, 1'b1, rr_val(0, 8), "R6 data read A");
        bus_write(1'b1, 1'b1, 8'hC3);
        check("R6 data write B reg8", 32'(wr_of(1, 8)), 32'hC3);
        bus_read(1'b0, 1'b0, rr_val(0, 2), "R6 index kept");

        // R7 register 8 through the index
        bus_write(1'b0, 1'b0, 8'h08);
        bus_write(1'b0, 1'b0, 8'h77);
        check("R7 A reg8 by index", 32'(wr_of(0, 8)), 32'h77);
        bus_write(1'b0, 1'b0, 8'h08);
        bus_read(1'b1, 1'b0, rr_val(1, 8), "R7 read B reg8 by index");

        // R10 long write, last data wins, no effect before strobe drops
        bus_write(1'b0, 1'b0, 8'h04);
        @(negedge clk);
        bus_ce = 1; bus_wr = 1; bus_dc = 0; bus_ch = 1; bus_wdata = 8'h11;
        @(negedge clk);
        bus_wdata = 8'h22;
        @(negedge clk);
        check("R10 no write during strobe", 32'(wr_of(1, 4)), 32'h00);
        @(negedge clk);
        bus_ce = 0; bus_wr = 0;
        check("R10 still no write", 32'(wr_of(1, 4)), 32'h00);
        @(negedge clk);
        check("R10 last data", 32'(wr_of(1, 4)), 32'h22);

        // R10 read and write together: no access, index stays 6
        bus_write(1'b0, 1'b0, 8'h06);
        @(negedge clk);
        bus_ce = 1; bus_rd = 1; bus_wr = 1; bus_dc = 0; bus_ch = 0; bus_wdata = 8'h99;
        #1;
        check("R9 oe with ce and rd", 32'(bus_rdata_oe), 32'd1);
        @(negedge clk);
        bus_ce = 0; bus_rd = 0; bus_wr = 0;
        @(negedge clk);
        check("R10 dual strobe no write", 32'(wr_of(0, 6)), 32'h00);
        bus_write(1'b0, 1'b0, 8'h44);
        check("R10 index survived", 32'(wr_of(0, 6)), 32'h44);

        // R9 no drive without read
        @(negedge clk);
        bus_rd = 1; bus_ce = 0;
        #1;
        check("R9 no oe without ce", 32'(bus_rdata_oe), 32'd0);
        check("R9 rdata zero", 32'(bus_rdata), 32'd0);
        bus_rd = 0;
        repeat (3) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule